// File: doc/BRIEF.md
# Write-Protect Command Sequence Guard

This block sits between a stream of qualified byte writes and a byte-wide non-volatile array made of several independent blocks. It watches the address/data pairs of each write and decides whether the write may reach the array. The decision is reported on `wr_allow` in the same cycle as the write strobe. Each block keeps its own protect flag. A short command prefix turns the flag on and also opens the current burst for payload data. A longer prefix turns the flag off.

Command bytes are fixed address/data pairs on the block's 17-bit byte address. Call them LEAD (data AAh at 05555h), SECOND (data 55h at 02AAAh), LOCK (data A0h at 05555h), EXTEND (data 80h at 05555h) and RELEASE (data 20h at 05555h). The arm sequence is LEAD, SECOND, LOCK. The clear sequence is LEAD, SECOND, EXTEND, LEAD, SECOND, RELEASE. Either sequence opens the burst, and the new flag value is applied when the external timer reports that the programming period has ended (`cycle_done`).

Each block has its own sequence tracker with eight named states:
- IDLE
- LEAD_SEEN
- SECOND_SEEN
- EXT_SEEN
- EXT_LEAD_SEEN
- EXT_SECOND_SEEN
- BURST_SET (open, protect on at period end)
- BURST_CLR (open, protect off at period end)

The named transitions are:
- **advance**: the expected command byte moves the tracker one step along.
- **restart**: an unexpected LEAD goes to LEAD_SEEN.
- **break**: any other unexpected byte goes to IDLE.
- **open**: LOCK or RELEASE goes to a BURST state.
- **close**: `cycle_done` returns every state to IDLE.

Top module: `wp_seq_guard`

## Requirements
- R1: After reset every bit of `prot_status` is 0 and `wr_allow` is 0 while `wr_strobe` is low.
- R2: A write that is not a command step, to a block whose protect bit is 0, gives `wr_allow`=1 in the cycle of the strobe.
- R3: The steps LEAD (AAh@05555h), SECOND (55h@02AAAh) and LOCK (A0h@05555h), sent in that order, each give `wr_allow`=0, whatever the protect bit. After LOCK, every later write to that block gives `wr_allow`=1 until `cycle_done`.
- R4: A completed arm sequence sets that block's bit of `prot_status` (bit index = block number) on the `cycle_done` cycle, even when no payload byte followed.
- R5: On a protected block in IDLE, a write without the prefix gives `wr_allow`=0.
- R6: The six steps LEAD, SECOND, EXTEND (80h@05555h), LEAD, SECOND, RELEASE (20h@05555h) each give `wr_allow`=0. Later writes in the burst are allowed, and the block's protect bit is cleared on `cycle_done`.
- R7: A write that does not match the expected next step (**break**) returns the tracker to IDLE and is judged as an ordinary write. If that write is a LEAD, it instead begins a new sequence (**restart**).
- R8: Writes to one block neither advance nor break another block's tracker, and each block's protect bit is independent.
- R9: While `pwr_good` is 0, no write is allowed, no tracker advances and no protect bit changes.
- R10: Protect bits change only in a cycle with `cycle_done`=1. A `cycle_done` discards any partial sequence.
- R11: `wr_allow` is never 1 while `wr_strobe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (factory state: unprotected) |
| pwr_good | input | 1 | Supply-good; when low all writes are inhibited |
| wr_strobe | input | 1 | One-cycle qualified byte write |
| wr_addr | input | ADDR_W (17) | Byte address within the block |
| wr_data | input | DATA_W (8) | Write data byte |
| wr_blk | input | BLK_W (1) | Target block number |
| cycle_done | input | 1 | End of the programming period |
| wr_allow | output | 1 | Write may reach the array (valid while `wr_strobe` is high) |
| prot_status | output | NUM_BLK (2) | Protect bit per block |

## Verification
The hardest state to reach is one where two block trackers are mid-sequence at the same time. A related hard case is a sequence that was interrupted by a power dip or by the end of a programming period, so that an apparently valid later step must be rejected. The stimulus reaches these states in three ways. It interleaves command steps to block 0 with plain writes to block 1. It sends LEAD while `pwr_good` is low and then sends the remaining steps. It issues `cycle_done` between SECOND and LOCK. In each case the scoreboard expects the later steps to be treated as ordinary writes to a protected block.

// File: rtl/wp_pkg.sv
package wp_pkg;

    // Classified meaning of one written address/data pair
    typedef enum logic [2:0] {
        TK_PLAIN,
        TK_LEAD,
        TK_SECOND,
        TK_LOCK,
        TK_EXTEND,
        TK_RELEASE
    } wp_tok_e;

    // Per-block sequence tracker states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD_SEEN,
        ST_SECOND_SEEN,
        ST_EXT_SEEN,
        ST_EXT_LEAD_SEEN,
        ST_EXT_SECOND_SEEN,
        ST_BURST_SET,
        ST_BURST_CLR
    } wp_state_e;

endpackage

// File: rtl/wp_cmd_decode.sv
module wp_cmd_decode
    import wp_pkg::*;
#(
    parameter int              ADDR_W       = 17,
    parameter int              DATA_W       = 8,
    parameter logic [ADDR_W-1:0] CMD_ADDR_A = 17'h05555,
    parameter logic [ADDR_W-1:0] CMD_ADDR_B = 17'h02AAA,
    parameter logic [DATA_W-1:0] CODE_LEAD    = 8'hAA,
    parameter logic [DATA_W-1:0] CODE_SECOND  = 8'h55,
    parameter logic [DATA_W-1:0] CODE_LOCK    = 8'hA0,
    parameter logic [DATA_W-1:0] CODE_EXTEND  = 8'h80,
    parameter logic [DATA_W-1:0] CODE_RELEASE = 8'h20
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output wp_tok_e           tok
);

    logic at_a;
    logic at_b;

    assign at_a = (addr == CMD_ADDR_A);
    assign at_b = (addr == CMD_ADDR_B);

    always_comb begin
        tok = TK_PLAIN;
        if (at_b && (data == CODE_SECOND)) begin
            tok = TK_SECOND;
        end else if (at_a) begin
            if (data == CODE_LEAD)         tok = TK_LEAD;
            else if (data == CODE_LOCK)    tok = TK_LOCK;
            else if (data == CODE_EXTEND)  tok = TK_EXTEND;
            else if (data == CODE_RELEASE) tok = TK_RELEASE;
            else                           tok = TK_PLAIN;
        end
    end

endmodule

// File: rtl/wp_blk_fsm.sv
module wp_blk_fsm
    import wp_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    hit,
    input  wp_tok_e tok,
    input  logic    cycle_done,
    output logic    allow,
    output logic    prot
);

    wp_state_e state_q;
    wp_state_e state_d;
    logic      step;
    logic      prot_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Protect flag: updated only when the programming period ends
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prot_q <= 1'b0;
        end else if (cycle_done) begin
            if (state_q == ST_BURST_SET)      prot_q <= 1'b1;
            else if (state_q == ST_BURST_CLR) prot_q <= 1'b0;
        end
    end

    // Next state and command-consumption flag
    always_comb begin
        state_d = state_q;
        step    = 1'b0;
        if (hit) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (tok == TK_LEAD) begin
                        state_d = ST_LEAD_SEEN;
                        step    = 1'b1;
                    end
                end
                ST_LEAD_SEEN: begin
                    step = 1'b1;
                    if (tok == TK_SECOND)    state_d = ST_SECOND_SEEN;
                    else if (tok == TK_LEAD) state_d = ST_LEAD_SEEN;
                    else begin
                        state_d = ST_IDLE;
                        step    = 1'b0;
                    end
                end
                ST_SECOND_SEEN: begin
                    step = 1'b1;
                    if (tok == TK_LOCK)        state_d = ST_BURST_SET;
                    else if (tok == TK_EXTEND) state_d = ST_EXT_SEEN;
                    else if (tok == TK_LEAD)   state_d = ST_LEAD_SEEN;
                    else begin
                        state_d = ST_IDLE;
                        step    = 1'b0;
                    end
                end
                ST_EXT_SEEN: begin
                    if (tok == TK_LEAD) begin
                        state_d = ST_EXT_LEAD_SEEN;
                        step    = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
                ST_EXT_LEAD_SEEN: begin
                    step = 1'b1;
                    if (tok == TK_SECOND)    state_d = ST_EXT_SECOND_SEEN;
                    else if (tok == TK_LEAD) state_d = ST_LEAD_SEEN;
                    else begin
                        state_d = ST_IDLE;
                        step    = 1'b0;
                    end
                end
                ST_EXT_SECOND_SEEN: begin
                    step = 1'b1;
                    if (tok == TK_RELEASE)   state_d = ST_BURST_CLR;
                    else if (tok == TK_LEAD) state_d = ST_LEAD_SEEN;
                    else begin
                        state_d = ST_IDLE;
                        step    = 1'b0;
                    end
                end
                ST_BURST_SET,
                ST_BURST_CLR: begin
                    state_d = state_q;
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
        if (cycle_done) begin
            state_d = ST_IDLE;
        end
    end

    // Outputs
    always_comb begin
        allow = 1'b0;
        if (hit) begin
            unique case (state_q)
                ST_BURST_SET,
                ST_BURST_CLR: allow = 1'b1;
                default:      allow = !step && !prot_q;
            endcase
        end
        prot = prot_q;
    end

endmodule

// File: rtl/wp_seq_guard.sv
module wp_seq_guard
    import wp_pkg::*;
#(
    parameter int NUM_BLK = 2,
    parameter int ADDR_W  = 17,
    parameter int DATA_W  = 8,
    localparam int BLK_W  = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic              wr_strobe,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BLK_W-1:0]  wr_blk,
    input  logic              cycle_done,
    output logic              wr_allow,
    output logic [NUM_BLK-1:0] prot_status
);

    wp_tok_e            tok;
    logic [NUM_BLK-1:0] hit_vec;
    logic [NUM_BLK-1:0] allow_vec;

    wp_cmd_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dec (
        .addr (wr_addr),
        .data (wr_data),
        .tok  (tok)
    );

    for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
        assign hit_vec[b] = wr_strobe && pwr_good && (wr_blk == BLK_W'(b));

        wp_blk_fsm u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .hit        (hit_vec[b]),
            .tok        (tok),
            .cycle_done (cycle_done),
            .allow      (allow_vec[b]),
            .prot       (prot_status[b])
        );
    end

    assign wr_allow = |allow_vec;

endmodule

// File: rtl/wp_seq_guard_chk.sv
module wp_seq_guard_chk #(
    parameter int NUM_BLK = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pwr_good,
    input logic               wr_strobe,
    input logic               cycle_done,
    input logic               wr_allow,
    input logic [NUM_BLK-1:0] prot_status
);

    // R1: reset leaves every block unprotected
    a_r1_reset_unprotected: assert property (@(posedge clk)
        !rst_n |=> (prot_status == '0));

    // R11: allow only accompanies a write strobe
    a_r11_allow_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        wr_allow |-> wr_strobe);

    // R9: brown-out inhibits every write
    a_r9_brownout_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |-> !wr_allow);

    // R10: protect bits move only at the end of a programming period
    a_r10_prot_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !cycle_done |=> $stable(prot_status));

    // R9: no protect change during brown-out without a period end
    a_r9_prot_held_low_power: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_good && !cycle_done) |=> $stable(prot_status));

endmodule

bind wp_seq_guard wp_seq_guard_chk #(.NUM_BLK(NUM_BLK)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_good    (pwr_good),
    .wr_strobe   (wr_strobe),
    .cycle_done  (cycle_done),
    .wr_allow    (wr_allow),
    .prot_status (prot_status)
);

// File: tb/sim_wp_seq_guard.sv
module sim_wp_seq_guard;

    localparam int NUM_BLK = 2;
    localparam int ADDR_W  = 17;
    localparam int DATA_W  = 8;
    localparam int BLK_W   = 1;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               pwr_good = 1'b1;
    logic               wr_strobe = 1'b0;
    logic [ADDR_W-1:0]  wr_addr = '0;
    logic [DATA_W-1:0]  wr_data = '0;
    logic [BLK_W-1:0]   wr_blk = '0;
    logic               cycle_done = 1'b0;
    logic               wr_allow;
    logic [NUM_BLK-1:0] prot_status;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    typedef struct {
        logic  exp;
        string tag;
    } item_t;
    item_t sb_q[$];

    always #5 clk = ~clk;

    wp_seq_guard #(.NUM_BLK(NUM_BLK), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .wr_strobe(wr_strobe),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_blk(wr_blk),
        .cycle_done(cycle_done), .wr_allow(wr_allow), .prot_status(prot_status)
    );

    // Monitor: compare allow against the scoreboard on each strobe
    always @(negedge clk) begin
        if (wr_strobe && !finished) begin
            if (sb_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL scoreboard underflow: actual=%0b expected=none", wr_allow);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                n_chk++;
                if (wr_allow !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: wr_allow actual=%0b expected=%0b", it.tag, wr_allow, it.exp);
                end
            end
        end
    end

    task automatic do_wr(input int blk, input logic [ADDR_W-1:0] a,
                         input logic [DATA_W-1:0] d, input logic exp, input string tag);
        item_t it;
        @(posedge clk); #2;
        wr_strobe = 1'b1; wr_addr = a; wr_data = d; wr_blk = BLK_W'(blk);
        it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        @(posedge clk); #2;
        wr_strobe = 1'b0;
    endtask

    task automatic seq_arm(input int blk, input string tag);
        do_wr(blk, 17'h05555, 8'hAA, 1'b0, tag);
        do_wr(blk, 17'h02AAA, 8'h55, 1'b0, tag);
        do_wr(blk, 17'h05555, 8'hA0, 1'b0, tag);
    endtask

    task automatic seq_clear(input int blk, input string tag);
        do_wr(blk, 17'h05555, 8'hAA, 1'b0, tag);
        do_wr(blk, 17'h02AAA, 8'h55, 1'b0, tag);
        do_wr(blk, 17'h05555, 8'h80, 1'b0, tag);
        do_wr(blk, 17'h05555, 8'hAA, 1'b0, tag);
        do_wr(blk, 17'h02AAA, 8'h55, 1'b0, tag);
        do_wr(blk, 17'h05555, 8'h20, 1'b0, tag);
    endtask

    task automatic done_pulse();
        @(posedge clk); #2; cycle_done = 1'b1;
        @(posedge clk); #2; cycle_done = 1'b0;
    endtask

    task automatic chk_prot(input logic [NUM_BLK-1:0] exp, input string tag);
        @(negedge clk);
        n_chk++;
        if (prot_status !== exp) begin
            n_fail++;
            $display("FAIL %s: prot_status actual=%b expected=%b", tag, prot_status, exp);
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1: factory state, no allow without strobe
        chk_prot(2'b00, "R1 reset");
        n_chk++;
        if (wr_allow !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 idle allow: actual=%0b expected=0", wr_allow);
        end

        // R2: plain writes on unprotected blocks
        do_wr(0, 17'h00010, 8'h3C, 1'b1, "R2 plain blk0");
        do_wr(1, 17'h1FFFF, 8'hAA, 1'b1, "R2 plain blk1 top addr");

        // R3 / R4: arm block 0 with payload
        seq_arm(0, "R3 arm steps denied");
        do_wr(0, 17'h00100, 8'h11, 1'b1, "R3 payload");
        do_wr(0, 17'h05555, 8'hAA, 1'b1, "R3 payload lookalike");
        chk_prot(2'b00, "R10 before done");
        done_pulse();
        chk_prot(2'b01, "R4 armed at done");

        // R5 / R8
        do_wr(0, 17'h00200, 8'h22, 1'b0, "R5 unprefixed denied");
        do_wr(1, 17'h00200, 8'h22, 1'b1, "R8 other block free");

        // R4: arm with no payload on a protected block keeps it protected
        seq_arm(0, "R4 re-arm steps");
        done_pulse();
        chk_prot(2'b01, "R4 re-arm no payload");
        do_wr(0, 17'h00300, 8'h33, 1'b0, "R5 after period");

        // R7: break and restart
        do_wr(0, 17'h05555, 8'hAA, 1'b0, "R7 lead");
        do_wr(0, 17'h00100, 8'h12, 1'b0, "R7 break protected");
        do_wr(1, 17'h05555, 8'hAA, 1'b0, "R7 lead blk1");
        do_wr(1, 17'h00010, 8'h33, 1'b1, "R7 break unprotected");
        do_wr(1, 17'h05555, 8'hAA, 1'b0, "R7 lead");
        do_wr(1, 17'h05555, 8'hAA, 1'b0, "R7 restart lead");
        do_wr(1, 17'h02AAA, 8'h55, 1'b0, "R7 second");
        do_wr(1, 17'h05555, 8'hA0, 1'b0, "R7 lock");
        do_wr(1, 17'h00044, 8'h44, 1'b1, "R7 payload after restart");
        done_pulse();
        chk_prot(2'b11, "R4 blk1 armed");

        // R8: interleaved blocks
        do_wr(0, 17'h05555, 8'hAA, 1'b0, "R8 blk0 lead");
        do_wr(1, 17'h00050, 8'h50, 1'b0, "R8 blk1 plain protected");
        do_wr(0, 17'h02AAA, 8'h55, 1'b0, "R8 blk0 second");
        do_wr(0, 17'h05555, 8'hA0, 1'b0, "R8 blk0 lock");
        do_wr(0, 17'h00060, 8'h60, 1'b1, "R8 blk0 payload");
        do_wr(1, 17'h00061, 8'h61, 1'b0, "R8 blk1 still locked");
        done_pulse();

        // R9: brown-out drops the lead step
        @(posedge clk); #2 pwr_good = 1'b0;
        do_wr(0, 17'h05555, 8'hAA, 1'b0, "R9 lead during brownout");
        chk_prot(2'b11, "R9 prot held");
        @(posedge clk); #2 pwr_good = 1'b1;
        do_wr(0, 17'h02AAA, 8'h55, 1'b0, "R9 second without lead");
        do_wr(0, 17'h05555, 8'hA0, 1'b0, "R9 lock without lead");
        do_wr(0, 17'h00070, 8'h70, 1'b0, "R9 payload rejected");

        // R6: clear block 0 with payload
        seq_clear(0, "R6 clear steps denied");
        do_wr(0, 17'h00080, 8'h80, 1'b1, "R6 payload");
        chk_prot(2'b11, "R10 clear pending");
        done_pulse();
        chk_prot(2'b10, "R6 cleared at done");
        do_wr(0, 17'h00090, 8'h90, 1'b1, "R6 plain after clear");

        // R10: cycle_done discards a partial sequence
        do_wr(1, 17'h05555, 8'hAA, 1'b0, "R10 lead");
        do_wr(1, 17'h02AAA, 8'h55, 1'b0, "R10 second");
        done_pulse();
        do_wr(1, 17'h05555, 8'hA0, 1'b0, "R10 orphan lock");
        do_wr(1, 17'h000A0, 8'hA1, 1'b0, "R10 no burst opened");
        chk_prot(2'b10, "R10 prot unchanged");

        // R6: clear without payload
        seq_clear(1, "R6 clear blk1");
        done_pulse();
        chk_prot(2'b00, "R6 clear no payload");
        do_wr(1, 17'h000B0, 8'hB0, 1'b1, "R6 blk1 free");

        // R11: no allow between strobes
        @(negedge clk);
        n_chk++;
        if (wr_allow !== 1'b0) begin
            n_fail++;
            $display("FAIL R11 allow without strobe: actual=%0b expected=0", wr_allow);
        end

        repeat (2) @(posedge clk);
        if (sb_q.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL scoreboard leftover: actual=%0d expected=0", sb_q.size());
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule